// File: doc/BRIEF.md
# Paged Memory-Map Address Translator

This block sits between an 8-bit CPU and its memory system. It turns every 16-bit CPU address into a wider physical address. The top four address bits select one of sixteen 4 KB pages. That page number, joined with a segment number, indexes a programmable table of bank entries. The chosen bank entry, followed by the untouched 12-bit page offset, forms the physical address. The translation path is purely combinational, so the physical address is valid in the same cycle as the CPU address.

Some accesses bypass the table. The topmost region of the address space, every access made while translation is off, and every read that a boot-time ROM overlay claims all take a fixed route. DMA accesses ignore the segment register. A small register hole inside the standard bank returns all-ones and asks the CPU for an extra wait state. The overlay window also asks for that wait state. In normal mode the physical address is 18 bits wide. In extended mode the full 8-bit bank entry can reach 20 bits.

The table is loaded through a synchronous write port. After reset every entry holds the standard bank for its own page, so the block starts out behaving as if translation were off.

Top module: `pgmap_xlat`

## Requirements
- R1: After reset, entry i of the table holds 0x30 | (i mod 16). With translation enabled, any address below 0xFC00 then maps to 0x30000 | address in every segment and mode.
- R2: A mapped access produces phys_addr = (effective entry << 12) | cpu_addr[11:0]. The entry is read at table index {segment, cpu_addr[15:12]}, with the segment in bits 6:4 of the index.
- R3: In normal mode (ext_mode=0), only seg_sel[1:0] forms the segment, so index bit 6 is 0. Only the low 6 bits of the entry are used, so phys_addr[19:18] is 0.
- R4: In extended mode (ext_mode=1), all three bits of seg_sel form the segment, and all 8 entry bits are used.
- R5: Addresses 0xFC00 to 0xFFFF that the overlay does not claim are never translated. They map to 0x30000 | address.
- R6: When dma_acc=1, segment 0 is used whatever seg_sel holds.
- R7: force_ff is 1 exactly when a mapped access has an effective entry of 0x3F and a page offset from 0xD80 to 0xD97.
- R8: When xlat_en=0, an access not claimed by the overlay maps to 0x30000 | address.
- R9: With rom_en=1, a read (acc_write=0) at 0x6000 to 0x7FFF or at 0xFFFE to 0xFFFF sets rom_sel=1 and phys_addr = address & 0x1FFF. This takes priority over every other route. Writes are never claimed by the overlay.
- R10: wait_req is 1 in the cycle after a cycle in which acc_strobe=1 and either rom_sel or force_ff is 1. It is 0 in every other cycle, including during reset.
- R11: A table write (map_we=1) at a rising clock edge stores map_wdata at index map_widx. Accesses from the next cycle onward see the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_strobe | input | 1 | Marks a cycle that carries a CPU or DMA access |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| cpu_addr | input | 16 | CPU address |
| dma_acc | input | 1 | Access made by DMA; forces segment 0 |
| xlat_en | input | 1 | Enables table translation |
| ext_mode | input | 1 | Extended mode: 3-bit segment and full 8-bit entry |
| seg_sel | input | 3 | Current segment register |
| rom_en | input | 1 | Enables the boot ROM overlay |
| map_we | input | 1 | Table write enable |
| map_widx | input | 7 | Table index to write |
| map_wdata | input | 8 | Bank entry to write |
| phys_addr | output | 20 | Physical address, or ROM offset when rom_sel is 1 |
| rom_sel | output | 1 | Access is served by the boot ROM overlay |
| force_ff | output | 1 | Access falls in the reserved hole; data reads as 0xFF |
| wait_req | output | 1 | One-cycle wait-state request |

## Verification
phys_addr, rom_sel and force_ff depend only on the inputs and on the table contents. They are due in the same cycle that the inputs are driven. The bench drives inputs on the falling edge and compares these outputs 3 ns later, before the next rising edge. wait_req is registered and is due one cycle later. The monitor therefore compares it against the wait decision it kept from the previous item. It expects 0 whenever the previous cycle carried no access. A table write is checked through the first access in the following cycle, so each entry is seen only after the edge that stored it.

// File: rtl/pgmap_pkg.sv
`timescale 1ns/1ps
package pgmap_pkg;

  // Route taken by one access through the translator.
  typedef enum logic [1:0] {
    RT_ROM   = 2'd0,
    RT_FIXED = 2'd1,
    RT_MAP   = 2'd2
  } route_e;

  // Default geometry shared by all units.
  localparam int unsigned VA_W_D    = 16;
  localparam int unsigned OFF_W_D   = 12;
  localparam int unsigned SEG_W_D   = 3;
  localparam int unsigned NSEG_W_D  = 2;
  localparam int unsigned ENT_W_D   = 8;
  localparam int unsigned NENT_W_D  = 6;
  localparam int unsigned ROMOFF_W_D = 13;

endpackage

// File: rtl/pgmap_table.sv
`timescale 1ns/1ps
module pgmap_table #(
  parameter int unsigned IDX_W = 7,
  parameter int unsigned ENT_W = 8,
  parameter int unsigned PG_W  = 4,
  parameter logic [7:0]  RESET_BANK = 8'h30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ENT_W-1:0] rd_entry
);
  localparam int unsigned DEPTH  = 1 << IDX_W;
  localparam int unsigned NPAGES = 1 << PG_W;

  logic [ENT_W-1:0] ent_q [DEPTH];

  // Reset value of one entry: the standard bank with the entry's own page.
  function automatic logic [ENT_W-1:0] f_home(input int unsigned i);
    return ENT_W'(RESET_BANK) | ENT_W'(i % NPAGES);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= f_home(i);
    end else if (wr_en) begin
      ent_q[wr_idx] <= wr_data;
    end
  end

  assign rd_entry = ent_q[rd_idx];

  // R11: a write lands at its index by the next cycle.
  p_write_lands_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent_q[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/pgmap_decode.sv
`timescale 1ns/1ps
module pgmap_decode import pgmap_pkg::*; #(
  parameter int unsigned VA_W     = VA_W_D,
  parameter int unsigned OFF_W    = OFF_W_D,
  parameter int unsigned SEG_W    = SEG_W_D,
  parameter int unsigned NSEG_W   = NSEG_W_D,
  parameter int unsigned ENT_W    = ENT_W_D,
  parameter int unsigned NENT_W   = NENT_W_D,
  parameter int unsigned ROMOFF_W = ROMOFF_W_D,
  parameter logic [15:0] BYPASS_FROM = 16'hFC00,
  parameter logic [19:0] FIXED_BASE  = 20'h30000,
  parameter logic [7:0]  HOLE_BANK   = 8'h3F,
  parameter logic [11:0] HOLE_LO     = 12'hD80,
  parameter logic [11:0] HOLE_HI     = 12'hD97,
  parameter logic [15:0] ROM_LO      = 16'h6000,
  parameter logic [15:0] ROM_HI      = 16'h7FFF,
  parameter logic [15:0] VEC_LO      = 16'hFFFE,
  localparam int unsigned PG_W  = VA_W - OFF_W,
  localparam int unsigned IDX_W = PG_W + SEG_W,
  localparam int unsigned PA_W  = ENT_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VA_W-1:0]  cpu_addr,
  input  logic             acc_write,
  input  logic             dma_acc,
  input  logic             xlat_en,
  input  logic             ext_mode,
  input  logic [SEG_W-1:0] seg_sel,
  input  logic             rom_en,
  input  logic [ENT_W-1:0] map_entry,
  output logic [IDX_W-1:0] map_idx,
  output logic [PA_W-1:0]  phys_addr,
  output route_e           route,
  output logic             hole
);
  localparam logic [SEG_W-1:0] NSEG_MASK = SEG_W'((1 << NSEG_W) - 1);
  localparam logic [ENT_W-1:0] NENT_MASK = ENT_W'((1 << NENT_W) - 1);

  logic [PG_W-1:0]  page;
  logic [OFF_W-1:0] off;
  logic [ENT_W-1:0] eff_ent;

  // Table index: DMA forces segment 0, normal mode keeps NSEG_W bits.
  function automatic logic [IDX_W-1:0] f_index(input logic [PG_W-1:0] pg,
      input logic [SEG_W-1:0] sg, input logic ext, input logic dma);
    logic [SEG_W-1:0] s;
    s = '0;
    if (!dma) s = ext ? sg : (sg & NSEG_MASK);
    return {s, pg};
  endfunction

  // Entry width used: full in extended mode, NENT_W bits otherwise.
  function automatic logic [ENT_W-1:0] f_mask(input logic [ENT_W-1:0] e,
      input logic ext);
    return ext ? e : (e & NENT_MASK);
  endfunction

  // Overlay claims reads in the ROM window and in the vector pair.
  function automatic logic f_rom_hit(input logic [VA_W-1:0] a,
      input logic wr, input logic en);
    logic win;
    win = ((a >= VA_W'(ROM_LO)) && (a <= VA_W'(ROM_HI))) || (a >= VA_W'(VEC_LO));
    return en && !wr && win;
  endfunction

  function automatic logic f_in_hole(input logic [ENT_W-1:0] e,
      input logic [OFF_W-1:0] o);
    return (e == ENT_W'(HOLE_BANK)) && (o >= OFF_W'(HOLE_LO)) && (o <= OFF_W'(HOLE_HI));
  endfunction

  function automatic logic [PA_W-1:0] f_fixed(input logic [VA_W-1:0] a);
    return PA_W'(FIXED_BASE) | PA_W'(a);
  endfunction

  always_comb begin
    page    = cpu_addr[VA_W-1:OFF_W];
    off     = cpu_addr[OFF_W-1:0];
    map_idx = f_index(page, seg_sel, ext_mode, dma_acc);
    eff_ent = f_mask(map_entry, ext_mode);
    if (f_rom_hit(cpu_addr, acc_write, rom_en))
      route = RT_ROM;
    else if (!xlat_en || (cpu_addr >= VA_W'(BYPASS_FROM)))
      route = RT_FIXED;
    else
      route = RT_MAP;
    unique case (route)
      RT_ROM:   phys_addr = PA_W'(cpu_addr[ROMOFF_W-1:0]);
      RT_FIXED: phys_addr = f_fixed(cpu_addr);
      default:  phys_addr = {eff_ent, off};
    endcase
    hole = (route == RT_MAP) && f_in_hole(eff_ent, off);
  end

  // R5: the top region passes through to the standard bank.
  p_bypass_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (route != RT_ROM && cpu_addr >= VA_W'(BYPASS_FROM)) |->
      (phys_addr[VA_W-1:0] == cpu_addr &&
       phys_addr[PA_W-1:VA_W] == FIXED_BASE[PA_W-1:VA_W] && !hole));

  // R8: translation off behaves as a fixed map.
  p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!xlat_en && route != RT_ROM) |->
      (phys_addr[VA_W-1:0] == cpu_addr && !hole));

  // R6: DMA never selects a segment other than 0.
  p_dma_seg0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_acc |-> map_idx[IDX_W-1:PG_W] == '0);

  // R3: normal mode stays inside 18 bits and the lower index half.
  p_normal_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && route == RT_MAP) |->
      (phys_addr[PA_W-1:NENT_W+OFF_W] == '0 && !map_idx[IDX_W-1]));

  // R7: a hole access addresses the hole range of the standard bank.
  p_hole_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hole |-> (phys_addr[PA_W-1:OFF_W] == ENT_W'(HOLE_BANK) &&
              phys_addr[OFF_W-1:0] >= OFF_W'(HOLE_LO) &&
              phys_addr[OFF_W-1:0] <= OFF_W'(HOLE_HI)));

  // R9: overlay results are small ROM offsets and never holes.
  p_rom_offset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (route == RT_ROM) |->
      (phys_addr[PA_W-1:ROMOFF_W] == '0 && !hole && !acc_write));

endmodule

// File: rtl/pgmap_waitgen.sv
`timescale 1ns/1ps
module pgmap_waitgen (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic need_wait,
  output logic wait_req
);
  logic fire;
  assign fire = strobe && need_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_req <= 1'b0;
    else        wait_req <= fire;
  end

  // R10: each qualifying strobe cycle gives a wait in the next cycle.
  p_wait_after_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> wait_req);

  // R10: no wait without a qualifying strobe in the previous cycle.
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !wait_req);

endmodule

// File: rtl/pgmap_xlat.sv
`timescale 1ns/1ps
module pgmap_xlat import pgmap_pkg::*; #(
  parameter int unsigned VA_W   = VA_W_D,
  parameter int unsigned OFF_W  = OFF_W_D,
  parameter int unsigned SEG_W  = SEG_W_D,
  parameter int unsigned ENT_W  = ENT_W_D,
  localparam int unsigned PG_W  = VA_W - OFF_W,
  localparam int unsigned IDX_W = PG_W + SEG_W,
  localparam int unsigned PA_W  = ENT_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_strobe,
  input  logic             acc_write,
  input  logic [VA_W-1:0]  cpu_addr,
  input  logic             dma_acc,
  input  logic             xlat_en,
  input  logic             ext_mode,
  input  logic [SEG_W-1:0] seg_sel,
  input  logic             rom_en,
  input  logic             map_we,
  input  logic [IDX_W-1:0] map_widx,
  input  logic [ENT_W-1:0] map_wdata,
  output logic [PA_W-1:0]  phys_addr,
  output logic             rom_sel,
  output logic             force_ff,
  output logic             wait_req
);
  logic [IDX_W-1:0] map_idx;
  logic [ENT_W-1:0] map_entry;
  route_e           route;
  logic             hole;
  logic             need_wait;

  pgmap_table #(
    .IDX_W (IDX_W),
    .ENT_W (ENT_W),
    .PG_W  (PG_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (map_we),
    .wr_idx   (map_widx),
    .wr_data  (map_wdata),
    .rd_idx   (map_idx),
    .rd_entry (map_entry)
  );

  pgmap_decode #(
    .VA_W  (VA_W),
    .OFF_W (OFF_W),
    .SEG_W (SEG_W),
    .ENT_W (ENT_W)
  ) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .acc_write (acc_write),
    .dma_acc   (dma_acc),
    .xlat_en   (xlat_en),
    .ext_mode  (ext_mode),
    .seg_sel   (seg_sel),
    .rom_en    (rom_en),
    .map_entry (map_entry),
    .map_idx   (map_idx),
    .phys_addr (phys_addr),
    .route     (route),
    .hole      (hole)
  );

  assign rom_sel   = (route == RT_ROM);
  assign force_ff  = hole;
  assign need_wait = rom_sel || hole;

  pgmap_waitgen u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (acc_strobe),
    .need_wait (need_wait),
    .wait_req  (wait_req)
  );

  // R9: the overlay and the hole never claim the same access.
  p_rom_hole_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_sel && force_ff));

endmodule

// File: tb/pgmap_xlat_bench.sv
`timescale 1ns/1ps
module pgmap_xlat_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_strobe = 1'b0, acc_write = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        dma_acc = 1'b0, xlat_en = 1'b0, ext_mode = 1'b0;
  logic [2:0]  seg_sel = '0;
  logic        rom_en = 1'b0, map_we = 1'b0;
  logic [6:0]  map_widx = '0;
  logic [7:0]  map_wdata = '0;
  logic [19:0] phys_addr;
  logic        rom_sel, force_ff, wait_req;

  always #4 clk = ~clk;  // 125 MHz

  pgmap_xlat u_pgmap_xlat (
    .clk(clk), .rst_n(rst_n), .acc_strobe(acc_strobe), .acc_write(acc_write),
    .cpu_addr(cpu_addr), .dma_acc(dma_acc), .xlat_en(xlat_en),
    .ext_mode(ext_mode), .seg_sel(seg_sel), .rom_en(rom_en),
    .map_we(map_we), .map_widx(map_widx), .map_wdata(map_wdata),
    .phys_addr(phys_addr), .rom_sel(rom_sel), .force_ff(force_ff),
    .wait_req(wait_req));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench copy of the table, kept from the written values only.
  int shadow [128];

  typedef struct packed {
    logic [19:0] phys;
    logic        rom;
    logic        ff;
    logic        need;
  } exp_t;

  exp_t  eq[$];
  string tq[$];

  // Reference model written in plain integer arithmetic.
  function automatic exp_t model(int a, bit dma, bit en, bit ext, int seg,
                                 bit ren, bit wr);
    exp_t r;
    int s, e, off;
    r = '0;
    off = a % 4096;
    if (ren && !wr && ((a >= 24576 && a <= 32767) || a >= 65534)) begin
      r.rom  = 1;
      r.phys = 20'((a >= 65534) ? a - 57344 : a - 24576);
    end else if (!en || a >= 64512) begin
      r.phys = 20'(196608 + a);
    end else begin
      s = dma ? 0 : (ext ? seg : seg % 4);
      e = shadow[s * 16 + a / 4096];
      if (!ext) e = e % 64;
      r.phys = 20'(e * 4096 + off);
      r.ff   = (e == 63) && off >= 3456 && off <= 3479;
    end
    r.need = r.rom || r.ff;
    return r;
  endfunction

  task automatic apply(int a, bit dma, bit en, bit ext, int seg, bit ren,
                       bit wr, string tag);
    exp_t r;
    string t;
    @(negedge clk);
    cpu_addr = 16'(a); dma_acc = dma; xlat_en = en; ext_mode = ext;
    seg_sel = 3'(seg); rom_en = ren; acc_write = wr; acc_strobe = 1'b1;
    r = model(a, dma, en, ext, seg, ren, wr);
    t = tag;
    if (t == "") begin
      if (r.rom)                 t = "R9";
      else if (!en)              t = "R8";
      else if (a >= 64512)       t = "R5";
      else if (r.ff)             t = "R7";
      else if (dma)              t = "R6";
      else if (ext)              t = "R4";
      else                       t = "R2 R3";
    end
    eq.push_back(r);
    tq.push_back(t);
  endtask

  task automatic quiet();
    @(negedge clk);
    acc_strobe = 1'b0;
  endtask

  task automatic map_write(int idx, int val);
    @(negedge clk);
    acc_strobe = 1'b0;
    map_we = 1'b1; map_widx = 7'(idx); map_wdata = 8'(val);
    @(negedge clk);
    map_we = 1'b0;
    shadow[idx] = val;
  endtask

  // Monitor: combinational outputs in the same cycle, wait one cycle later.
  initial begin
    bit   prev_need;
    exp_t r;
    string t;
    prev_need = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      #3;
      checks++;
      if (wait_req !== prev_need) begin
        fails++;
        $display("FAIL R10 wait_req=%0b expected %0b at %0t", wait_req, prev_need, $time);
      end
      if (eq.size() > 0) begin
        r = eq.pop_front();
        t = tq.pop_front();
        checks++;
        if (phys_addr !== r.phys || rom_sel !== r.rom || force_ff !== r.ff) begin
          fails++;
          $display("FAIL %s addr=%h phys=%h rom=%0b ff=%0b expected phys=%h rom=%0b ff=%0b",
                   t, cpu_addr, phys_addr, rom_sel, force_ff, r.phys, r.rom, r.ff);
        end
        prev_need = r.need && acc_strobe;
      end else begin
        prev_need = 0;
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) shadow[i] = 48 + (i % 16);
    repeat (3) @(negedge clk);
    // R10: no wait during reset.
    checks++;
    if (wait_req !== 1'b0) begin
      fails++;
      $display("FAIL R10 wait_req=%0b expected 0 in reset", wait_req);
    end
    rst_n = 1'b1;

    // R1: default table behaves as untranslated in every segment.
    for (int ext = 0; ext < 2; ext++)
      for (int seg = 0; seg < 8; seg++)
        for (int pg = 0; pg < 15; pg++)
          apply(pg * 4096 + 291 + seg, 0, 1, 1'(ext), seg, 0, 0, "R1");
    quiet();

    // R11: a write is visible to the very next access.
    map_write(7'h12, 8'h5A);
    apply(16'h2ABC, 0, 1, 0, 1, 0, 0, "R11");
    quiet();

    // Load a varied table; page 3 entries become the standard bank.
    for (int i = 0; i < 128; i++) begin
      if (i % 16 == 3)   map_write(i, 8'h3F);
      else if (i == 23)  map_write(i, 8'hBF);
      else               map_write(i, (i * 37 + 11) % 256);
    end

    // R2, R3, R4, R6, R7, R5: sweep every segment, page, mode and DMA flag.
    for (int ext = 0; ext < 2; ext++)
      for (int dma = 0; dma < 2; dma++)
        for (int seg = 0; seg < 8; seg++)
          for (int pg = 0; pg < 16; pg++) begin
            apply(pg * 4096 + 3456 + ((seg * 16 + pg) % 32), 1'(dma), 1, 1'(ext), seg, 0, 0, "");
            apply(pg * 4096 + ((seg * 419 + pg * 81) % 4096), 1'(dma), 1, 1'(ext), seg, 0, 0, "");
          end
    quiet();

    // R7: hole edges in the standard bank.
    apply(16'h3D7F, 0, 1, 0, 0, 0, 0, "R7");
    apply(16'h3D80, 0, 1, 0, 0, 0, 0, "R7");
    apply(16'h3D97, 0, 1, 0, 2, 0, 0, "R7");
    apply(16'h3D98, 0, 1, 0, 0, 0, 0, "R7");
    apply(16'h7D90, 0, 1, 0, 5, 0, 0, "R7");  // 0xBF masked in normal mode
    apply(16'h7D90, 0, 1, 1, 1, 0, 0, "R7");  // full 0xBF: no hole
    quiet();

    // R9: overlay windows, priority and writes.
    apply(16'h6000, 0, 1, 0, 1, 1, 0, "R9");
    apply(16'h7FFF, 0, 1, 1, 6, 1, 0, "R9");
    apply(16'hFFFE, 0, 0, 0, 0, 1, 0, "R9");
    apply(16'hFFFF, 1, 1, 0, 0, 1, 0, "R9");
    apply(16'h5FFF, 0, 1, 0, 1, 1, 0, "R9");
    apply(16'hFFFD, 0, 1, 0, 1, 1, 0, "R9");
    apply(16'h6000, 0, 1, 0, 1, 1, 1, "R9");
    apply(16'h6000, 0, 1, 0, 1, 0, 0, "R9");
    quiet();

    // R8: translation off.
    apply(16'h0000, 0, 0, 0, 3, 0, 0, "R8");
    apply(16'h3D85, 0, 0, 1, 7, 0, 0, "R8");
    apply(16'hABCD, 1, 0, 1, 2, 0, 0, "R8");
    apply(16'hFC00, 0, 1, 1, 4, 0, 0, "R5");
    quiet();

    // R10: strobe low on a qualifying address gives no wait.
    @(negedge clk);
    cpu_addr = 16'h6000; rom_en = 1'b1; acc_write = 1'b0; acc_strobe = 1'b0;
    quiet();
    repeat (3) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule